// File: doc/BRIEF.md
# Port-expander register slave on a two-wire serial bus

This block is the serial-bus target side of a 16-bit general-purpose port expander. It watches the clock and data lines of a two-wire bus (I2C), sampled in a much faster system clock, and answers only to its own 7-bit address. The address is a fixed high part followed by the levels of a few strap inputs. A write transfer carries a command byte that sets a register pointer, and any data bytes after it. A read transfer returns register contents from the pointer. The block acknowledges and sends data by pulling the data line low through an output enable. It never drives the line high.

Eight byte-wide registers sit behind the pointer, in four pairs: input, output, polarity inversion and direction. After every data byte the pointer moves to the other member of its pair, so a master can stream both halves of a 16-bit quantity in either order. The stored output, polarity and direction values are brought out to the pad and interrupt logic. A one-cycle strobe per port tells the interrupt logic when an input byte has been taken for transmission.

Top module: `pxr_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits equal binary 0100 followed by `strap[2:0]` (strap[2] most significant). It acknowledges by asserting `sda_pull` through the high phase of the ninth clock. Bit 0 of the address byte selects a read when 1 and a write when 0.
- R2: The block does not acknowledge an address byte that does not match, including the all-zero general call address. `sda_pull` stays low until the next start condition.
- R3: The first byte after a write address is loaded as the pointer. Only its bits [2:0] are used, and bits [7:3] are ignored. Pointer values: 0/1 input ports 0/1, 2/3 output ports 0/1, 4/5 polarity ports 0/1, 6/7 direction ports 0/1.
- R4: After each data byte, whether written or read, pointer bit 0 flips while bits [2:1] stay. The sequence 3 then 2 then 3 and so on continues for any number of bytes.
- R5: A read transfer with no new pointer byte starts at the stored pointer. A repeated start keeps the pointer value that was current when it occurred.
- R6: Bytes written while the pointer selects register 0 or 1 are acknowledged and change no register.
- R7: After reset, `out_val` = 16'hFFFF, `pol_val` = 16'h0000, `cfg_val` = 16'hFFFF, `sda_pull` = 0 and `rd_strobe` = 0.
- R8: After a master NACK on a read byte, `sda_pull` is low and the block ignores the bus until the next start condition.
- R9: A read of an output, polarity or direction register returns the stored byte. A read of input register p returns `pin_lvl[8p+7:8p]` XOR polarity byte p, sampled on the rising clock edge of the acknowledge bit before that byte is sent.
- R10: `rd_strobe[p]` pulses for one cycle each time input register p is sampled for transmission, and never for both ports at once.
- R11: A stop condition returns the block to idle at any bit position, and a partly received byte is discarded. A start condition at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| strap | input | 3 | Low address bits from strap pins |
| pin_lvl | input | 16 | Pin levels, port 1 in [15:8], port 0 in [7:0] |
| sda_pull | output | 1 | When high, the data line is pulled low |
| out_val | output | 16 | Stored output-port values |
| pol_val | output | 16 | Stored polarity-inversion values |
| cfg_val | output | 16 | Stored direction values, 1 = input |
| rd_strobe | output | 2 | Per-port pulse when an input byte is sampled for a read |

## Verification
The bench writes each register pair starting from either member. A pointer that advances instead of flipping would read back the wrong byte in that case. It also sends a pointer byte with upper bits set and writes to the input registers; a decoder that uses the full byte, or a write path without the input-register guard, would corrupt a stored value. Repeated starts after a completed data byte, and reads with no pointer byte, catch a design that reloads the old command or loses the flipped pointer. A stop in the middle of a byte, a foreign address and the general call check that no stray write happens and no stray acknowledge is driven.

// File: rtl/pxr_pkg.sv
`timescale 1ns/1ps
package pxr_pkg;
   localparam int BYTE_W   = 8;
   localparam int NPORT    = 2;
   localparam int PTR_W    = 3;
   localparam int BIT_CNT_W = 4;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
   } pxr_state_e;

   // Register group, selected by pointer bits [2:1]
   localparam logic [1:0] GRP_IN  = 2'b00;
   localparam logic [1:0] GRP_OUT = 2'b01;
   localparam logic [1:0] GRP_POL = 2'b10;
   localparam logic [1:0] GRP_CFG = 2'b11;
endpackage

// File: rtl/pxr_sync.sv
`timescale 1ns/1ps
module pxr_sync #(
   parameter int         STAGES  = 2,
   parameter int         W       = 1,
   parameter logic [W-1:0] RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st[s] <= RST_VAL;
            else if (s == 0) st[s] <= d;
            else st[s] <= st[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/pxr_busmon.sv
`timescale 1ns/1ps
module pxr_busmon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/pxr_regs.sv
`timescale 1ns/1ps
module pxr_regs
   import pxr_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [PTR_W-1:0]        wr_sel,
   input  logic [BYTE_W-1:0]       wr_data,
   input  logic [PTR_W-1:0]        rd_sel,
   input  logic [NPORT*BYTE_W-1:0] pin_lvl,
   output logic [BYTE_W-1:0]       rd_data,
   output logic [NPORT*BYTE_W-1:0] out_val,
   output logic [NPORT*BYTE_W-1:0] pol_val,
   output logic [NPORT*BYTE_W-1:0] cfg_val
);
   logic [BYTE_W-1:0] out_q [NPORT];
   logic [BYTE_W-1:0] pol_q [NPORT];
   logic [BYTE_W-1:0] cfg_q [NPORT];

   genvar p;
   generate
      for (p = 0; p < NPORT; p++) begin : g_port
         logic hit;
         assign hit = wr_en && (wr_sel[0] == p[0]);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_q[p] <= '1;
               pol_q[p] <= '0;
               cfg_q[p] <= '1;
            end else if (hit) begin
               case (wr_sel[2:1])
                  GRP_OUT: out_q[p] <= wr_data;
                  GRP_POL: pol_q[p] <= wr_data;
                  GRP_CFG: cfg_q[p] <= wr_data;
                  default: ;
               endcase
            end
         end

         assign out_val[p*BYTE_W +: BYTE_W] = out_q[p];
         assign pol_val[p*BYTE_W +: BYTE_W] = pol_q[p];
         assign cfg_val[p*BYTE_W +: BYTE_W] = cfg_q[p];
      end
   endgenerate

   always_comb begin
      case (rd_sel[2:1])
         GRP_IN:  rd_data = pin_lvl[rd_sel[0]*BYTE_W +: BYTE_W] ^ pol_q[rd_sel[0]];
         GRP_OUT: rd_data = out_q[rd_sel[0]];
         GRP_POL: rd_data = pol_q[rd_sel[0]];
         default: rd_data = cfg_q[rd_sel[0]];
      endcase
   end
endmodule

// File: rtl/pxr_i2c_slave.sv
`timescale 1ns/1ps
module pxr_i2c_slave
   import pxr_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STRAP_W     = 3,
   parameter logic [6-STRAP_W:0] ADDR_PREFIX = 4'b0100
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    scl_i,
   input  logic                    sda_i,
   input  logic [STRAP_W-1:0]      strap,
   input  logic [NPORT*BYTE_W-1:0] pin_lvl,
   output logic                    sda_pull,
   output logic [NPORT*BYTE_W-1:0] out_val,
   output logic [NPORT*BYTE_W-1:0] pol_val,
   output logic [NPORT*BYTE_W-1:0] cfg_val,
   output logic [NPORT-1:0]        rd_strobe
);
   localparam int ADDR_W = 7;
   localparam logic [BIT_CNT_W-1:0] FULL = BIT_CNT_W'(BYTE_W);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("pxr_i2c_slave: SYNC_STAGES must be at least 2");
      end
      if (STRAP_W < 1 || STRAP_W > 6) begin : g_bad_strap
         $error("pxr_i2c_slave: STRAP_W must be 1..6");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   pxr_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   pxr_busmon u_mon (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   pxr_state_e             state;
   logic [BIT_CNT_W-1:0]   cnt;
   logic [BYTE_W-1:0]      shft, tx;
   logic [PTR_W-1:0]       ptr;
   logic                   rw, mack, sda_pull_q;
   logic [NPORT-1:0]       rd_strobe_q;
   logic [BYTE_W-1:0]      rd_data;
   logic                   wr_en, ptr_step, cap, byte_end;

   assign byte_end = scl_fall && (cnt == FULL);
   assign wr_en    = (state == ST_WR) && byte_end;
   assign ptr_step = wr_en || ((state == ST_RD) && byte_end);
   assign cap      = scl_rise && (((state == ST_ADDR_ACK) && rw) ||
                                  ((state == ST_RD_ACK) && !sda_s));

   pxr_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(ptr), .wr_data(shft),
      .rd_sel(ptr), .pin_lvl(pin_lvl), .rd_data(rd_data),
      .out_val(out_val), .pol_val(pol_val), .cfg_val(cfg_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         shft        <= '0;
         tx          <= '0;
         ptr         <= '0;
         rw          <= 1'b0;
         mack        <= 1'b0;
         sda_pull_q  <= 1'b0;
         rd_strobe_q <= '0;
      end else begin
         rd_strobe_q <= '0;
         if (cap) begin
            tx <= rd_data;
            if (ptr[2:1] == GRP_IN) rd_strobe_q[ptr[0]] <= 1'b1;
         end
         if (stop_det) begin
            state      <= ST_IDLE;
            sda_pull_q <= 1'b0;
         end else if (start_det) begin
            state      <= ST_ADDR;
            cnt        <= '0;
            sda_pull_q <= 1'b0;
         end else begin
            case (state)
               ST_ADDR, ST_CMD, ST_WR: begin
                  if (scl_rise) begin
                     shft <= {shft[BYTE_W-2:0], sda_s};
                     cnt  <= cnt + 1'b1;
                  end else if (byte_end) begin
                     if (state == ST_ADDR) begin
                        if (shft[BYTE_W-1:1] == ADDR_W'({ADDR_PREFIX, strap})) begin
                           rw         <= shft[0];
                           sda_pull_q <= 1'b1;
                           state      <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        if (state == ST_CMD) ptr <= shft[PTR_W-1:0];
                        else                 ptr <= {ptr[2:1], ~ptr[0]};
                        sda_pull_q <= 1'b1;
                        state      <= (state == ST_CMD) ? ST_CMD_ACK : ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        state      <= ST_RD;
                        sda_pull_q <= ~tx[BYTE_W-1];
                        cnt        <= BIT_CNT_W'(1);
                     end else begin
                        state      <= ST_CMD;
                        sda_pull_q <= 1'b0;
                        cnt        <= '0;
                     end
                  end
               end
               ST_CMD_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     state      <= ST_WR;
                     sda_pull_q <= 1'b0;
                     cnt        <= '0;
                  end
               end
               ST_RD: begin
                  if (byte_end) begin
                     sda_pull_q <= 1'b0;
                     ptr        <= {ptr[2:1], ~ptr[0]};
                     state      <= ST_RD_ACK;
                  end else if (scl_fall) begin
                     tx         <= {tx[BYTE_W-2:0], 1'b0};
                     sda_pull_q <= ~tx[BYTE_W-2];
                     cnt        <= cnt + 1'b1;
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) mack <= ~sda_s;
                  if (scl_fall) begin
                     if (mack) begin
                        state      <= ST_RD;
                        sda_pull_q <= ~tx[BYTE_W-1];
                        cnt        <= BIT_CNT_W'(1);
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_pull  = sda_pull_q;
   assign rd_strobe = rd_strobe_q;
endmodule

// File: rtl/pxr_i2c_slave_chk.sv
`timescale 1ns/1ps
module pxr_i2c_slave_chk
   import pxr_pkg::*;
(
   input logic                    clk,
   input logic                    rst_n,
   input pxr_state_e              state,
   input logic [PTR_W-1:0]        ptr,
   input logic                    ptr_step,
   input logic                    stop_det,
   input logic                    scl_fall,
   input logic                    sda_pull,
   input logic [NPORT-1:0]        rd_strobe,
   input logic [NPORT*BYTE_W-1:0] out_val,
   input logic [NPORT*BYTE_W-1:0] pol_val,
   input logic [NPORT*BYTE_W-1:0] cfg_val
);
   AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_val == '1 && pol_val == '0 && cfg_val == '1 && !sda_pull)); // R7

   AST_PTR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_step |=> (ptr == {$past(ptr[2:1]), ~$past(ptr[0])})); // R4

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(rd_strobe)); // R10

   AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_pull)); // R11

   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_pull); // R8

   AST_REG_CHANGE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({out_val, pol_val, cfg_val}) |-> $past(scl_fall)); // R3
endmodule

bind pxr_i2c_slave pxr_i2c_slave_chk u_chk (
   .clk(clk), .rst_n(rst_n), .state(state), .ptr(ptr), .ptr_step(ptr_step),
   .stop_det(stop_det), .scl_fall(scl_fall), .sda_pull(sda_pull),
   .rd_strobe(rd_strobe), .out_val(out_val), .pol_val(pol_val), .cfg_val(cfg_val));

// File: tb/pxr_i2c_slave_bench.sv
`timescale 1ns/1ps
module pxr_i2c_slave_bench;
   localparam int Q = 10;
   localparam logic [15:0] PINS = 16'h5AC3;
   localparam logic [2:0]  STRAP = 3'b101;
   localparam logic [7:0]  AW = {4'b0100, STRAP, 1'b0};
   localparam logic [7:0]  AR = {4'b0100, STRAP, 1'b1};
   localparam int NV = 6;
   // {command, first data, second data}
   localparam logic [23:0] VEC [NV] = '{
      {8'h02, 8'hAA, 8'h55},
      {8'h03, 8'h12, 8'h34},
      {8'hF5, 8'hC3, 8'h3C},
      {8'h06, 8'h0F, 8'hF0},
      {8'h00, 8'h77, 8'h88},
      {8'h0C, 8'hFF, 8'h01}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic sda_pull;
   logic [15:0] out_val, pol_val, cfg_val;
   logic [1:0]  rd_strobe;
   wire sda_bus = sda_m & ~sda_pull;

   int n_run = 0, n_fail = 0, stb0 = 0, stb1 = 0;
   logic [7:0] mreg [8];
   logic [2:0] ptr_m;
   logic done = 1'b0;

   always #4 clk = ~clk;

   pxr_i2c_slave u_pxr_i2c_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap(STRAP),
      .pin_lvl(PINS), .sda_pull(sda_pull), .out_val(out_val), .pol_val(pol_val),
      .cfg_val(cfg_val), .rd_strobe(rd_strobe));

   always @(negedge clk) if (rst_n) begin
      stb0 = stb0 + int'(rd_strobe[0]);
      stb1 = stb1 + int'(rd_strobe[1]);
   end

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic qw; repeat (Q) @(negedge clk); endtask

   task automatic b_start;
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic b_stop;
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
   endtask

   task automatic send_bit(input logic b);
      sda_m = b; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); ack = ~sda_bus; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         qw(); scl_m = 1'b1; qw(); b[i] = sda_bus; qw(); scl_m = 1'b0;
      end
      qw();
      sda_m = ~mack; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw(); sda_m = 1'b1;
   endtask

   function automatic logic [7:0] expv(input logic [2:0] p);
      if (p[2:1] == 2'b00) return PINS[p[0]*8 +: 8] ^ mreg[{2'b10, p[0]}];
      return mreg[p];
   endfunction

   task automatic chk_ports(input string tag);
      chk({tag, " out"}, out_val, {mreg[3], mreg[2]});
      chk({tag, " pol"}, pol_val, {mreg[5], mreg[4]});
      chk({tag, " cfg"}, cfg_val, {mreg[7], mreg[6]});
   endtask

   task automatic wr_data(input logic [7:0] d);
      logic a;
      send_byte(d, a);
      chk("R6 data ack", {15'd0, a}, 16'd1);
      if (ptr_m[2:1] != 2'b00) mreg[ptr_m] = d;
      ptr_m[0] = ~ptr_m[0];
   endtask

   task automatic rd_check(input logic mack, input string tag);
      logic [7:0] b;
      recv_byte(mack, b);
      chk(tag, {8'h00, b}, {8'h00, expv(ptr_m)});
      ptr_m[0] = ~ptr_m[0];
   endtask

   task automatic set_cmd(input logic [7:0] c);
      logic a;
      b_start();
      send_byte(AW, a); chk("R1 write address ack", {15'd0, a}, 16'd1);
      send_byte(c, a);  chk("R3 command ack", {15'd0, a}, 16'd1);
      ptr_m = c[2:0];
   endtask

   task automatic to_read;
      logic a;
      b_start();
      send_byte(AR, a); chk("R1 read address ack", {15'd0, a}, 16'd1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      logic a;
      int s0, s1;
      mreg[0] = 8'h00; mreg[1] = 8'h00;
      mreg[2] = 8'hFF; mreg[3] = 8'hFF;
      mreg[4] = 8'h00; mreg[5] = 8'h00;
      mreg[6] = 8'hFF; mreg[7] = 8'hFF;
      ptr_m = 3'd0;
      repeat (5) @(negedge clk);
      chk("R7 pull at reset", {15'd0, sda_pull}, 16'd0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_ports("R7 reset");
      chk("R7 strobe at reset", {14'd0, rd_strobe}, 16'd0);

      // R2: foreign address and general call
      b_start();
      send_byte(8'h40, a); chk("R2 foreign address", {15'd0, a}, 16'd0);
      send_byte(8'h00, a); chk("R2 no ack after mismatch", {15'd0, a}, 16'd0);
      b_stop();
      b_start();
      send_byte(8'h00, a); chk("R2 general call", {15'd0, a}, 16'd0);
      b_stop();
      chk_ports("R2 no change");

      // Table: write a pair, then read it back over a repeated start
      for (int v = 0; v < NV; v++) begin
         set_cmd(VEC[v][23:16]);
         wr_data(VEC[v][15:8]);
         wr_data(VEC[v][7:0]);
         b_stop();
         chk_ports("R4 R6 table write");
         if (v == 4) begin s0 = stb0; s1 = stb1; end
         set_cmd(VEC[v][23:16]);
         to_read();
         rd_check(1'b1, "R9 table read 1");
         rd_check(1'b1, "R4 table read 2");
         rd_check(1'b0, "R4 table read 3");
         b_stop();
         if (v == 4) begin
            chk("R10 port0 strobes", 16'(stb0 - s0), 16'd2);
            chk("R10 port1 strobes", 16'(stb1 - s1), 16'd1);
         end
      end

      // R5: read with no pointer byte starts from stored pointer
      to_read();
      rd_check(1'b1, "R5 direct read 1");
      rd_check(1'b0, "R5 direct read 2");
      b_stop();

      // R5: repeated start after one written byte keeps the flipped pointer
      set_cmd(8'h03);
      wr_data(8'h9E);
      to_read();
      rd_check(1'b0, "R5 restart keeps pair member");
      qw();
      chk("R8 released after nack", {15'd0, sda_pull}, 16'd0);
      send_byte(AR, a);
      chk("R8 ignored until start", {15'd0, a}, 16'd0);
      b_stop();
      chk_ports("R5 restart write");

      // R11: stop inside a data byte discards it
      set_cmd(8'h02);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      b_stop();
      chk_ports("R11 partial byte dropped");
      to_read();
      rd_check(1'b0, "R11 pointer after stop");
      b_stop();

      // R10: input port 1 then 0 strobes
      s0 = stb0; s1 = stb1;
      set_cmd(8'h01);
      to_read();
      rd_check(1'b1, "R9 input port1");
      rd_check(1'b0, "R9 input port0");
      b_stop();
      chk("R10 port1 single strobe", 16'(stb1 - s1), 16'd1);
      chk("R10 port0 single strobe", 16'(stb0 - s0), 16'd1);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule